// File: doc/BRIEF.md
# Serial Measurement Register Reader

This block is a serial-bus slave that lets a host fetch a small bank of 24-bit measurement values: active energy, reactive energy, line voltage and line frequency. The four values are presented on parallel input ports by the measurement logic. The host raises an active-high select, clocks in a short read command, and then receives register contents most significant bit first. The slave keeps streaming into the following registers for as long as select stays high.

A read command is a start-of-command pattern `1,1,0` followed by a six-bit register address, sent most significant bit first. Any number of zeros may come before the pattern, so a host with a fixed 16-bit word length can pad the command. Only the low four address bits select a register. The serial pins (select, serial clock, data in) are asynchronous to the system clock. They are resynchronised with two-flop stages, and all serial edges are detected in the system clock domain. The data output comes with an output-enable, so a pad driver can tri-state it whenever the block is not selected.

The register values need no handshake. Each value is sampled at the instant its first data bit is required. A value that changes during a read therefore never mixes old and new bits within one word.

Top module: `meter_spi_reader`

## Requirements
- R1: `sdo_en` is 0 in any cycle in which `spi_sel` is 0, and it drops in the same cycle that `spi_sel` falls.
- R2: Serial clock edges that occur while `spi_sel` is 0 are ignored. A command that follows them decodes normally.
- R3: Zeros received before the first 1 of a transaction are skipped, from none up to any count.
- R4: If the two bits after the leading 1 are not `1,0`, the slave keeps `sdo_en` at 0 for the rest of the transaction.
- R5: Address bits A5 and A4 (the first two address bits sent) do not affect which register is selected.
- R6: A3..A0 select a register as follows: `0000` active energy, `0001` reactive energy, `0010` voltage, `1011` frequency.
- R7: On the serial clock rising edge that carries A0, the slave sets `sdo_en` to 1 and drives `sdo_data` to 0.
- R8: Each later rising edge presents the next data bit. A register is sent D23 first and D0 last, 24 bits per register.
- R9: After D0 the slave continues at once with the next register, in the order active, reactive, voltage, frequency, and wraps from frequency to active.
- R10: An unmapped address returns 24 zero bits and then continues with active energy.
- R11: A register value is sampled on the edge that presents its D23. Changes made to it after that edge do not affect the word being sent.
- R12: A fall of `spi_sel` abandons any partly received command. The next transaction decodes from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sel | input | 1 | Chip select, active high, asynchronous |
| spi_sclk | input | 1 | Serial clock from the host, asynchronous |
| spi_sdi | input | 1 | Serial data from the host |
| sdo_data | output | 1 | Serial data to the host (0 when not enabled) |
| sdo_en | output | 1 | Output enable for the tri-state data pad |
| val_active | input | 24 | Active energy value |
| val_reactive | input | 24 | Reactive energy value |
| val_voltage | input | 24 | Voltage value |
| val_freq | input | 24 | Frequency value |

## Verification
Two cases are hard to reach from the pins. The first is a register value that changes while a read is in progress; the second is a select that drops halfway through the address field. For the first, the bench rewrites the active and reactive values in the middle of the active word. It then expects the old active bits but the new reactive word, because the model samples each value at the edge that emits D23. For the second, the bench sends a truncated command, lowers select, and then expects the next full command to return voltage rather than a word shifted by the left-over bits.

// File: rtl/meter_spi_pkg.sv
package meter_spi_pkg;

  localparam int ADDR_W = 6;
  localparam int N_REGS = 4;
  localparam int IDX_W  = $clog2(N_REGS);

  typedef enum logic [2:0] {
    CMD_HUNT,
    CMD_HDR,
    CMD_ADDR,
    CMD_STREAM,
    CMD_DEAD
  } cmd_state_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } reg_sel_t;

  // Low four address bits to register slot; slot order is also the
  // continuation order.
  function automatic reg_sel_t map_reg(input logic [3:0] low);
    reg_sel_t r;
    r.hit = 1'b1;
    case (low)
      4'b0000: r.idx = IDX_W'(0);
      4'b0001: r.idx = IDX_W'(1);
      4'b0010: r.idx = IDX_W'(2);
      4'b1011: r.idx = IDX_W'(3);
      default: begin
        r.hit = 1'b0;
        r.idx = '0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/meter_spi_sync.sv
module meter_spi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] stage [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
      prev <= '0;
    end else begin
      stage[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
      prev <= stage[STAGES-1];
    end
  end

  assign sync_out = stage[STAGES-1];

  for (genvar b = 0; b < W; b++) begin : g_edge
    assign rise[b] = stage[STAGES-1][b] & ~prev[b];
    assign fall[b] = ~stage[STAGES-1][b] & prev[b];
  end

endmodule

// File: rtl/meter_spi_cmd.sv
module meter_spi_cmd
  import meter_spi_pkg::*;
#(
  parameter int          HDR_W   = 3,
  parameter logic [HDR_W-1:0] HDR_PAT = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sclk_rise,
  input  logic              din,
  output logic              stream_on,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr,
  output logic              adv
);

  localparam int MAXC  = (HDR_W > ADDR_W) ? HDR_W : ADDR_W;
  localparam int CNT_W = $clog2(MAXC);

  cmd_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [HDR_W-1:0] hdr_left;
  logic [ADDR_W-1:0] addr;
  logic             bit_in;

  assign bit_in = sel & sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CMD_HUNT;
      cnt      <= '0;
      hdr_left <= '0;
      addr     <= '0;
    end else if (!sel) begin
      state    <= CMD_HUNT;
      cnt      <= '0;
      hdr_left <= '0;
      addr     <= '0;
    end else if (sclk_rise) begin
      case (state)
        CMD_HUNT: if (din) begin
          state    <= CMD_HDR;
          cnt      <= CNT_W'(1);
          hdr_left <= HDR_PAT << 1;
        end
        CMD_HDR: begin
          if (din != hdr_left[HDR_W-1]) begin
            state <= CMD_DEAD;
          end else if (cnt == CNT_W'(HDR_W-1)) begin
            state <= CMD_ADDR;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
          hdr_left <= hdr_left << 1;
        end
        CMD_ADDR: begin
          addr <= {addr[ADDR_W-2:0], din};
          if (cnt == CNT_W'(ADDR_W-1)) state <= CMD_STREAM;
          else                         cnt   <= cnt + CNT_W'(1);
        end
        default: state <= state;
      endcase
    end
  end

  assign start      = bit_in && (state == CMD_ADDR) && (cnt == CNT_W'(ADDR_W-1));
  assign start_addr = {addr[ADDR_W-2:0], din};
  assign adv        = bit_in && (state == CMD_STREAM);
  assign stream_on  = (state == CMD_STREAM);

  assert_dead_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CMD_DEAD && sel) |=> (state == CMD_DEAD));

  assert_start_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

endmodule

// File: rtl/meter_spi_shift.sv
module meter_spi_shift
  import meter_spi_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [ADDR_W-1:0]              start_addr,
  input  logic                           adv,
  input  logic [N_REGS-1:0][DATA_W-1:0]  reg_vals,
  output logic                           dout
);

  localparam int CNT_W = $clog2(DATA_W);

  logic [IDX_W-1:0]  cur_idx;
  logic              cur_zero;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] shreg;
  logic [DATA_W-1:0] word;
  reg_sel_t          first_sel;

  assign first_sel = map_reg(start_addr[3:0]);
  assign word      = cur_zero ? '0 : reg_vals[cur_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx  <= '0;
      cur_zero <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
      dout     <= 1'b0;
    end else if (start) begin
      cur_idx  <= first_sel.idx;
      cur_zero <= ~first_sel.hit;
      bit_cnt  <= '0;
      dout     <= 1'b0;
    end else if (adv) begin
      if (bit_cnt == '0) begin
        dout     <= word[DATA_W-1];
        shreg    <= word[DATA_W-2:0];
        bit_cnt  <= CNT_W'(DATA_W-1);
        cur_zero <= 1'b0;
        if (cur_zero || cur_idx == IDX_W'(N_REGS-1)) cur_idx <= '0;
        else                                          cur_idx <= cur_idx + IDX_W'(1);
      end else begin
        dout    <= shreg[DATA_W-2];
        shreg   <= shreg << 1;
        bit_cnt <= bit_cnt - CNT_W'(1);
      end
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(DATA_W-1));

  assert_zero_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !start && cur_zero) |=> (!dout && !cur_zero && cur_idx == '0));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !start && bit_cnt == '0 && !cur_zero && cur_idx == IDX_W'(N_REGS-1))
      |=> (cur_idx == '0));

endmodule

// File: rtl/meter_spi_reader.sv
module meter_spi_reader
  import meter_spi_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sel,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  output logic              sdo_data,
  output logic              sdo_en,
  input  logic [DATA_W-1:0] val_active,
  input  logic [DATA_W-1:0] val_reactive,
  input  logic [DATA_W-1:0] val_voltage,
  input  logic [DATA_W-1:0] val_freq
);

  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] s_bus, s_rise, s_fall;
  logic              s_sel, s_din, sclk_rise;
  logic              stream_on, start, adv, dout_bit;
  logic [ADDR_W-1:0] start_addr;
  logic [N_REGS-1:0][DATA_W-1:0] reg_vals;

  meter_spi_sync #(.W(SYNC_W), .STAGES(2)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({spi_sdi, spi_sclk, spi_sel}),
    .sync_out (s_bus),
    .rise     (s_rise),
    .fall     (s_fall)
  );

  assign s_sel     = s_bus[0];
  assign s_din     = s_bus[2];
  assign sclk_rise = s_rise[1];

  meter_spi_cmd i_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (s_sel),
    .sclk_rise  (sclk_rise),
    .din        (s_din),
    .stream_on  (stream_on),
    .start      (start),
    .start_addr (start_addr),
    .adv        (adv)
  );

  assign reg_vals = {val_freq, val_voltage, val_reactive, val_active};

  meter_spi_shift #(.DATA_W(DATA_W)) i_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .adv        (adv),
    .reg_vals   (reg_vals),
    .dout       (dout_bit)
  );

  assign sdo_en   = spi_sel & stream_on;
  assign sdo_data = sdo_en & dout_bit;

  assert_low_after_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (stream_on && !dout_bit));

  assert_stop_on_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    s_fall[0] |=> !stream_on);

  assert_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_sel |-> !sdo_en);

endmodule

// File: tb/test_meter_spi_reader.sv
module test_meter_spi_reader;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int DW         = 24;

  logic clk = 0, rst_n = 0;
  logic spi_sel = 0, spi_sclk = 0, spi_sdi = 0;
  logic sdo_data, sdo_en;
  logic [DW-1:0] r_act = 24'hA5C3F1, r_rea = 24'h13579B, r_vol = 24'h00F0E1, r_frq = 24'h8E0042;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  meter_spi_reader i_meter_spi_reader (
    .clk(clk), .rst_n(rst_n), .spi_sel(spi_sel), .spi_sclk(spi_sclk), .spi_sdi(spi_sdi),
    .sdo_data(sdo_data), .sdo_en(sdo_en),
    .val_active(r_act), .val_reactive(r_rea), .val_voltage(r_vol), .val_freq(r_frq)
  );

  function automatic logic [DW-1:0] reg_of(input int idx);
    case (idx)
      0: return r_act;
      1: return r_rea;
      2: return r_vol;
      default: return r_frq;
    endcase
  endfunction

  function automatic int map_idx(input logic [3:0] a);
    case (a)
      4'b0000: return 0;
      4'b0001: return 1;
      4'b0010: return 2;
      4'b1011: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string req, input logic ge, input logic gd, input logic ee, input logic ed);
    checks++;
    if (ge !== ee || (ee && gd !== ed)) begin
      errors++;
      $display("FAIL %s: en=%0b data=%0b expected en=%0b data=%0b", req, ge, gd, ee, ed);
    end
  endtask

  // Every clock: deselected means no drive (R1).
  always begin
    @(negedge clk); #2;
    if (rst_n && !spi_sel && !done) chk("R1 idle", sdo_en, sdo_data, 1'b0, 1'b0);
  end

  task automatic sbit(input logic b, output logic e, output logic d);
    spi_sdi = b;
    repeat (HALF) @(negedge clk);
    spi_sclk = 1;
    repeat (6) @(negedge clk);
    #1; e = sdo_en; d = sdo_data;
    repeat (2) @(negedge clk);
    spi_sclk = 0;
  endtask

  task automatic release_sel();
    @(negedge clk);
    spi_sel = 0;
    #1 chk("R1 release", sdo_en, sdo_data, 1'b0, 1'b0);
    repeat (12) @(negedge clk);
  endtask

  task automatic frame(input int pad, input logic [2:0] hdr, input logic [5:0] a,
                       input int nread, input int chg_bit, input string tag);
    logic e, d;
    logic [8:0] cmd;
    bit ok;
    int idx, pos;
    bit zero;
    logic [DW-1:0] w;
    string t;
    cmd = {hdr, a};
    ok = (hdr == 3'b110);
    @(negedge clk); spi_sel = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < pad; i++) begin
      sbit(1'b0, e, d);
      chk({tag, " R3 pad"}, e, d, 1'b0, 1'b0);
    end
    for (int i = 8; i >= 0; i--) begin
      sbit(cmd[i], e, d);
      if (i == 0 && ok) chk({tag, " R7 low after A0"}, e, d, 1'b1, 1'b0);
      else              chk({tag, ok ? " R3 command" : " R4 command"}, e, d, 1'b0, 1'b0);
    end
    idx = map_idx(a[3:0]);
    zero = (idx < 0);
    pos = 0;
    w = '0;
    for (int k = 0; k < nread; k++) begin
      if (pos == 0) begin
        w = zero ? '0 : reg_of(idx);
        t = (k == 0) ? (zero ? " R10 R8" : " R6 R8") : (zero ? " R10 R9" : " R9 R8");
        if (zero) begin idx = 0; zero = 0; end
        else idx = (idx + 1) % 4;
      end
      sbit(1'b0, e, d);
      if (ok) chk({tag, t}, e, d, 1'b1, w[DW-1-pos]);
      else    chk({tag, " R4 silent"}, e, d, 1'b0, 1'b0);
      if (k == chg_bit) begin
        r_act = ~r_act;
        r_rea = r_rea ^ 24'h5A5A5A;
      end
      pos = (pos + 1) % DW;
    end
    release_sel();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1 chk("R1 reset", sdo_en, sdo_data, 1'b0, 1'b0);

    // R2: serial clocks with select low carrying a valid-looking command
    begin
      logic [8:0] junk;
      logic e, d;
      junk = 9'b110_000010;
      for (int i = 8; i >= 0; i--) begin
        sbit(junk[i], e, d);
        chk("R2 deselected clocks", e, d, 1'b0, 1'b0);
      end
    end
    frame(7, 3'b110, 6'b000000, 48, -1, "R2 R3 16-bit frame");
    frame(0, 3'b110, 6'b110010, 24, -1, "R5 upper bits");
    frame(3, 3'b110, 6'b001011, 72, -1, "R9 wrap");
    frame(1, 3'b110, 6'b000101, 48, -1, "R10 unmapped");
    frame(2, 3'b111, 6'b000000, 30, -1, "R4 bad 111");
    frame(0, 3'b100, 6'b000001, 20, -1, "R4 bad 100");

    // R12: abort mid-address, then a fresh voltage read
    begin
      logic [8:0] part;
      logic e, d;
      part = 9'b110_101000;
      @(negedge clk); spi_sel = 1;
      repeat (4) @(negedge clk);
      for (int i = 8; i >= 5; i--) begin
        sbit(part[i], e, d);
        chk("R12 partial", e, d, 1'b0, 1'b0);
      end
      release_sel();
    end
    frame(0, 3'b110, 6'b000010, 24, -1, "R12 fresh");

    frame(4, 3'b110, 6'b000000, 48, 10, "R11 midread change");
    frame(5, 3'b110, 6'b010001, 24, -1, "R6 reactive");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule